// File: doc/BRIEF.md
# BCD Gate Width Pulse Generator

This block turns a start edge into one gate pulse whose length is a decimal number of counts. The width is an eight-digit packed BCD word. Each count lasts a fixed number of system clocks (`CLKS_PER_COUNT`); with a 250 MHz clock and the default of 25, one count is 100 ns, so the range is 100 ns to 9.9999999 s. The launch edge captures the width. A chain of BCD digit counters then counts up from zero, and the gate closes on the count where the counter word equals the captured width.

Two markers go with each gate. The begin marker covers the first count of the gate. The end marker starts in the cycle the gate closes and lasts one count. The block is non-updating: while the gate or the end marker is high, start edges have no effect. A new gate can start in the first clock after the end marker drops.

The choice between a locally set width and a bus-written width is made outside this block.

Top module: `gate_pulse_gen`

## Requirements
- R1: After reset, `gateOut`, `beginMark` and `endMark` are all low and stay low until a start edge arrives.
- R2: A rising edge on `startIn`, seen while the block is idle, raises `gateOut` on the next clock. The gate stays high for exactly N × `CLKS_PER_COUNT` clocks. N is the BCD value of `widthBcd`: digit k sits in bits 4k+3..4k, and digit 0 is the least significant. Holding `startIn` high never starts a second gate.
- R3: `beginMark` rises in the same cycle as `gateOut`, stays high for the first `CLKS_PER_COUNT` clocks of the gate, and is never high while the gate is low.
- R4: `endMark` rises in the cycle `gateOut` falls and stays high for exactly `CLKS_PER_COUNT` clocks. It is never high at the same time as the gate.
- R5: Start edges that arrive while `gateOut` is high neither lengthen nor restart the gate, and they produce no later gate.
- R6: Start edges that arrive while `endMark` is high are ignored. A start edge in the first clock after `endMark` falls is accepted.
- R7: A width of all zero digits gives a gate of one count.
- R8: The width is captured at launch. Changing `widthBcd` while the gate is high does not change that gate's length.
- R9: Any digit code from 10 to 15 in `widthBcd` counts as 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start request; its rising edge launches a gate |
| widthBcd | input | 4*DIGITS | Gate width as packed BCD, digit 0 in the lowest nibble |
| gateOut | output | 1 | Gate pulse; also the gate-open status |
| beginMark | output | 1 | One-count marker at the start of the gate |
| endMark | output | 1 | One-count marker starting at the end of the gate |

## Verification
The state that matters is inside: the captured width, the prescaler phase and the BCD digit chain. A wrong value in any of them shows at the ports within one gate.

- **Broken carry or bad comparison.** The gate length is off by a multiple of the count period. Widths with several digits expose this, for example 12, 93, or a width with a clamped digit.
- **Prescaler phase not reset at launch.** The begin marker is shorter or longer than one count.
- **Lost end state.** The end marker has the wrong length, or a start edge in the cycle after it is refused.
- **Retrigger leak.** An extra gate appears that the scoreboard never expected.

// File: rtl/gate_pulse_pkg.sv
package gate_pulse_pkg;

  typedef enum logic [1:0] {
    GP_IDLE = 2'd0,
    GP_GATE = 2'd1,
    GP_TAIL = 2'd2
  } gp_state_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;     // capture width, clear prescaler and digits
    logic stepEn;   // prescaler advances
    logic countEn;  // digit chain advances on tick
    logic zero;     // clear digit chain
  } gp_strobe_t;

endpackage

// File: rtl/gate_bcd_digit.sv
module gate_bcd_digit (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       carryIn,
  output logic [3:0] val,
  output logic [3:0] nextVal,
  output logic       carryOut
);

  always_comb begin
    carryOut = carryIn && (val == 4'd9);
    if (!carryIn)            nextVal = val;
    else if (val == 4'd9)    nextVal = 4'd0;
    else                     nextVal = val + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)    val <= 4'd0;
    else if (clr) val <= 4'd0;
    else          val <= nextVal;
  end

endmodule

// File: rtl/gate_pulse_dp.sv
module gate_pulse_dp
  import gate_pulse_pkg::*;
#(
  parameter int DIGITS         = 8,
  parameter int CLKS_PER_COUNT = 25
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gp_strobe_t            strobe,
  input  logic [4*DIGITS-1:0]   widthBcd,
  output logic                  tick,
  output logic                  hitNext,
  output logic                  countZero
);

  localparam int WORD_W = 4 * DIGITS;
  localparam int PRE_W  = (CLKS_PER_COUNT > 1) ? $clog2(CLKS_PER_COUNT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_COUNT - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [WORD_W-1:0] clampWord;
  logic [WORD_W-1:0] targetWord;
  logic [WORD_W-1:0] countWord;
  logic [WORD_W-1:0] nextWord;
  logic [DIGITS:0]   carry;

  // prescaler: one tick per count
  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)              preCnt <= '0;
    else if (strobe.load)   preCnt <= '0;
    else if (strobe.stepEn) preCnt <= tick ? '0 : preCnt + PRE_W'(1);
  end

  // width capture with digit clamp
  logic [WORD_W-1:0] clampRaw;

  genvar gi;
  generate
    for (gi = 0; gi < DIGITS; gi++) begin : g_clamp
      logic [3:0] rawDigit;
      assign rawDigit = widthBcd[4*gi +: 4];
      assign clampRaw[4*gi +: 4] = (rawDigit > 4'd9) ? 4'd9 : rawDigit;
    end
  endgenerate

  always_comb begin
    clampWord = clampRaw;
    if (clampRaw == '0) clampWord[3:0] = 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            targetWord <= WORD_W'(1);
    else if (strobe.load) targetWord <= clampWord;
  end

  // BCD digit chain
  assign carry[0] = strobe.countEn && tick;

  generate
    for (gi = 0; gi < DIGITS; gi++) begin : g_digit
      gate_bcd_digit u_digit (
        .clk      (clk),
        .rstN     (rstN),
        .clr      (strobe.zero || strobe.load),
        .carryIn  (carry[gi]),
        .val      (countWord[4*gi +: 4]),
        .nextVal  (nextWord[4*gi +: 4]),
        .carryOut (carry[gi+1])
      );
    end
  endgenerate

  assign hitNext   = carry[0] && (nextWord == targetWord);
  assign countZero = (countWord == '0);

endmodule

// File: rtl/gate_pulse_ctrl.sv
module gate_pulse_ctrl
  import gate_pulse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       tick,
  input  logic       hitNext,
  output gp_strobe_t strobe,
  output logic       gateOut,
  output logic       endMark
);

  gp_state_t state, stateNext;
  logic      startQ;
  logic      startEdge;

  always_ff @(posedge clk) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= startIn;
  end

  assign startEdge = startIn && !startQ;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      GP_IDLE: begin
        strobe.zero = 1'b1;
        if (startEdge) begin
          strobe.load = 1'b1;
          stateNext   = GP_GATE;
        end
      end
      GP_GATE: begin
        strobe.stepEn  = 1'b1;
        strobe.countEn = 1'b1;
        if (hitNext) begin
          strobe.zero = 1'b1;
          stateNext   = GP_TAIL;
        end
      end
      GP_TAIL: begin
        strobe.stepEn = 1'b1;
        if (tick) stateNext = GP_IDLE;
      end
      default: stateNext = GP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= GP_IDLE;
    else       state <= stateNext;
  end

  assign gateOut = (state == GP_GATE);
  assign endMark = (state == GP_TAIL);

endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen
  import gate_pulse_pkg::*;
#(
  parameter int DIGITS         = 8,
  parameter int CLKS_PER_COUNT = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic [4*DIGITS-1:0] widthBcd,
  output logic                gateOut,
  output logic                beginMark,
  output logic                endMark
);

  gp_strobe_t strobe;
  logic       tick;
  logic       hitNext;
  logic       countZero;

  gate_pulse_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .tick    (tick),
    .hitNext (hitNext),
    .strobe  (strobe),
    .gateOut (gateOut),
    .endMark (endMark)
  );

  gate_pulse_dp #(
    .DIGITS         (DIGITS),
    .CLKS_PER_COUNT (CLKS_PER_COUNT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .widthBcd  (widthBcd),
    .tick      (tick),
    .hitNext   (hitNext),
    .countZero (countZero)
  );

  // first count of the gate
  assign beginMark = gateOut && countZero;

endmodule

// File: rtl/gate_pulse_chk.sv
module gate_pulse_chk #(
  parameter int CLKS_PER_COUNT = 25
) (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic gateOut,
  input logic beginMark,
  input logic endMark
);

  localparam int RUN_W = $clog2(CLKS_PER_COUNT + 2);

  logic [RUN_W-1:0] endRun;

  always_ff @(posedge clk) begin
    if (!rstN)        endRun <= '0;
    else if (endMark) endRun <= endRun + RUN_W'(1);
    else              endRun <= '0;
  end

  // R1
  p_quiet_until_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> $past(startIn));

  // R2
  p_launch_from_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> !$past(gateOut) && !$past(endMark));

  // R3
  p_begin_inside_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    beginMark |-> gateOut);

  p_begin_with_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> beginMark);

  // R4
  p_end_after_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOut) |-> endMark);

  p_end_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(endMark && gateOut));

  p_end_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    endMark |-> (endRun < RUN_W'(CLKS_PER_COUNT)));

  // R5
  p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beginMark) |-> $rose(gateOut));

  // R6
  p_tail_blocks_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    endMark |=> !gateOut);

endmodule

bind gate_pulse_gen gate_pulse_chk #(
  .CLKS_PER_COUNT (CLKS_PER_COUNT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .gateOut   (gateOut),
  .beginMark (beginMark),
  .endMark   (endMark)
);

// File: tb/sim_gate_pulse_gen.sv
`timescale 1ns/1ps
module sim_gate_pulse_gen;

  localparam int DIGITS = 8;
  localparam int DIV    = 3;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                startIn = 1'b0;
  logic [4*DIGITS-1:0] widthBcd = '0;
  logic                gateOut, beginMark, endMark;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;
  int expQ[$];

  always #2 clk = ~clk;

  gate_pulse_gen #(.DIGITS(DIGITS), .CLKS_PER_COUNT(DIV)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .widthBcd(widthBcd),
    .gateOut(gateOut), .beginMark(beginMark), .endMark(endMark)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures each pulse and compares with the queue
  int  gateCnt = 0, begCnt = 0, endCnt = 0;
  logic prevGate = 1'b0, prevEnd = 1'b0;
  bit  armed = 1'b0;

  always @(negedge clk) begin
    if (armed) begin
      if (gateOut && !prevGate) begin
        chk("R3 begin rises with gate", int'(beginMark), 1);
        if (expQ.size() == 0) begin
          nCmp++; nBad++;
          $display("FAIL R5 unexpected gate actual=1 expected=0");
        end
      end
      if (gateOut) begin
        gateCnt++;
        if (beginMark) begCnt++;
      end
      if (prevGate && !gateOut) begin
        if (expQ.size() != 0) chk("R2 gate length", gateCnt, expQ.pop_front());
        chk("R3 begin length", begCnt, DIV);
        chk("R4 end rises as gate falls", int'(endMark), 1);
        gateCnt = 0; begCnt = 0;
      end
      if (endMark) endCnt++;
      if (prevEnd && !endMark) begin
        chk("R4 end length", endCnt, DIV);
        endCnt = 0;
      end
      prevGate = gateOut;
      prevEnd  = endMark;
    end
  end

  // driver
  task automatic fire(input logic [4*DIGITS-1:0] w, input int counts);
    @(negedge clk);
    widthBcd = w;
    startIn  = 1'b1;
    expQ.push_back(counts * DIV);
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (gateOut || endMark);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 gate low after reset", int'(gateOut), 0);
    chk("R1 begin low after reset", int'(beginMark), 0);
    chk("R1 end low after reset", int'(endMark), 0);
    armed = 1'b1;

    fire(32'h0000_0005, 5);   waitIdle();   // R2 single digit
    fire(32'h0000_0012, 12);  waitIdle();   // R2 carry across digits
    fire(32'h0000_0000, 1);   waitIdle();   // R7 zero width
    fire(32'h0000_000C, 9);   waitIdle();   // R9 clamped digit
    fire(32'h0000_00A3, 93);  waitIdle();   // R9 clamped upper digit

    // R2 held start: stays high past the gate, no second gate
    @(negedge clk);
    widthBcd = 32'h0000_0002;
    startIn  = 1'b1;
    expQ.push_back(2 * DIV);
    repeat (20) @(negedge clk);
    startIn = 1'b0;
    waitIdle();

    // R5 start edges during the gate
    fire(32'h0000_0008, 8);
    repeat (4) @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    waitIdle();

    // R8 width change during the gate
    fire(32'h0000_0006, 6);
    repeat (3) @(negedge clk);
    widthBcd = 32'h0000_0040;
    waitIdle();

    // R6 start during end marker ignored, start right after accepted
    fire(32'h0000_0002, 2);
    do @(negedge clk); while (!endMark);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    do @(negedge clk); while (endMark);
    widthBcd = 32'h0000_0003;
    startIn  = 1'b1;
    expQ.push_back(3 * DIV);
    @(negedge clk);
    chk("R6 start after end marker accepted", int'(gateOut), 1);
    startIn = 1'b0;
    waitIdle();

    repeat (10) @(negedge clk);
    chk("R5 no pending gates", expQ.size(), 0);
    chk("R1 outputs idle at end", int'(gateOut || endMark), 0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        nCmp++; nBad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule